// File: doc/BRIEF.md
# Cycle-Steal Host Memory Port

This block lets an external host reach one word of on-chip memory at a time without stopping the processor core for more than a single cycle. The host raises its select strobe together with a write or read strobe. The port immediately reports busy on its acknowledge line and brings the request into the core's timing. It then raises a cycle-steal request and waits until the core's current cycle can give way. Any external memory wait states, a low-power slow idle with its divisor, or an external bus handed to another master can lengthen this wait. Once the core gives way, the port performs the memory access in exactly one stolen core cycle and then returns the acknowledge to ready.

Time is modelled on one fast clock, `clk2x`, that runs at twice the core rate. A phase flag, `core_phase`, marks the second half of every core cycle, so all half-cycle events of the core fall on `clk2x` edges. The stall situation of the core arrives on input ports: the number of external accesses in the current instruction, their wait-state count, the slow-idle flag and divisor, and a bus-hold flag. Two lower-priority cycle stealers, a block transfer engine and a serial autobuffer, get their grants from the same arbiter. The host always wins over both of them.

Top module: `hdma_steal_port`

## Requirements
- R1: While reset is asserted, host_ack, steal_req, mem_en, bdma_gnt, abuf_gnt and core_phase are all low.
- R2: A rising edge of (host_sel AND (host_wr OR host_rd)) sampled on a clk2x edge while host_ack is low drives host_ack high from that edge. The access is a write when host_wr is high and a read otherwise, so write wins when both strobes are high.
- R3: steal_req rises on the first clk2x edge after the start edge at which core_phase turns to 1. This places it 1 or 2 clk2x cycles after host_ack rises.
- R4: Let x be ext_acc_cnt (0 to 3) and W be ext_wait. Then E = 0 for x = 0 and E = x*W + x - 1 otherwise. With no hold and no slow idle, mem_en starts at the first edge where core_phase turns to 0 that lies at least 1+2E clk2x cycles after the steal_req edge.
- R5: While slow_idle is high, E equals slow_div, whatever the value of ext_acc_cnt.
- R6: The stolen access begins only on an edge at which bus_hold is sampled low. Holding bus_hold high postpones it with no limit.
- R7: mem_en is high for exactly one clk2x cycle, with core_phase low. During that cycle mem_we equals the latched write flag and mem_addr/mem_wdata carry the values latched at the start edge. steal_req falls as mem_en rises.
- R8: After a read, host_rdata holds the mem_rdata value presented in the cycle after mem_en. It is valid once host_ack is low again. A write leaves host_rdata unchanged.
- R9: host_ack falls 3 clk2x cycles after the start of the mem_en cycle.
- R10: At every core boundary (the edge where core_phase goes from 1 to 0), grants for the next core cycle are chosen. No grant is given if the host access starts on that edge. Otherwise bdma_gnt is given if bdma_req is high, else abuf_gnt if abuf_req is high. At most one grant is high at any time.
- R11: A rising request while host_ack is high is ignored and changes no latched value. A request still held when host_ack returns low does not start a new access.
- R12: The total number of clk2x cycles with host_ack high is 1+2E+4 or 1+2E+5 when there is no hold. With no external access this is 5 or 6 cycles, which is 2.5 to 3 core clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host select strobe, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Word address of the access |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data returned to the host |
| host_ack | output | 1 | High while busy, low when ready |
| ext_acc_cnt | input | EXT_W | External accesses in the core's current cycle |
| ext_wait | input | WS_W | Wait states per external access |
| slow_idle | input | 1 | Core is in slow idle |
| slow_div | input | DIV_W | Slow-idle divisor n |
| bus_hold | input | 1 | External bus granted away and core stalled on it |
| bdma_req | input | 1 | Block transfer steal request |
| abuf_req | input | 1 | Serial autobuffer steal request |
| bdma_gnt | output | 1 | Block transfer owns the next core cycle |
| abuf_gnt | output | 1 | Autobuffer owns the next core cycle |
| steal_req | output | 1 | Host cycle-steal request pending |
| core_phase | output | 1 | High in the second half of a core cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one clk2x cycle after mem_en |

## Verification
The case hardest to reach from the ports is a stolen access held off by a granted external bus while a lower-priority stealer is also asking. Here the access edge depends both on when bus_hold drops and on the core phase. The bench raises bus_hold together with the host strobe and keeps it high for several cycles beyond the computed wait, with bdma_req and abuf_req active. A per-cycle reference model then checks that mem_en appears only at the first phase-aligned edge after the hold drops and that no grant collides with it. Start edges are deliberately placed on both core phases, so both sync latencies occur. A second rising request is injected while the port is busy, with both strobes high on the first request.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ACC_A = 3'd3,
    ST_ACC_B = 3'd4,
    ST_REL   = 3'd5
  } steal_st_e;

endpackage

// File: rtl/hdma_phase_gen.sv
module hdma_phase_gen (
  input  logic clk2x,
  input  logic rst_n,
  output logic ph
);

  logic ph_d;

  always_comb ph_d = ~ph;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ph_d;
  end

endmodule

// File: rtl/hdma_req_front.sv
module hdma_req_front #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept,
  output logic              start,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              lat_wr
);

  logic req_now;
  logic req_q;

  always_comb begin
    req_now = sel & (wr | rd);
    start   = accept & req_now & ~req_q;
  end

  // previous request level, for edge detection
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_now;
  end

  // access descriptor latched only on an accepted start
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_wr    <= 1'b0;
    end else if (start) begin
      lat_addr  <= addr;
      lat_wdata <= wdata;
      lat_wr    <= wr;
    end
  end

endmodule

// File: rtl/hdma_wait_calc.sv
module hdma_wait_calc #(
  parameter int EXT_MAX = 3,
  parameter int EXT_W   = 2,
  parameter int WS_W    = 4,
  parameter int DIV_W   = 4,
  parameter int CNT_W   = 7
) (
  input  logic [EXT_W-1:0] ext_cnt,
  input  logic [WS_W-1:0]  ws,
  input  logic             slow,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] halves
);

  logic [CNT_W-1:0] ext_eff;
  logic [CNT_W-1:0] extra_ext;
  logic [CNT_W-1:0] extra;

  always_comb begin
    if (CNT_W'(ext_cnt) > CNT_W'(EXT_MAX)) ext_eff = CNT_W'(EXT_MAX);
    else                                    ext_eff = CNT_W'(ext_cnt);

    // first external access costs W, each further one 1+W
    if (ext_eff == '0) extra_ext = '0;
    else extra_ext = ext_eff * CNT_W'(ws) + ext_eff - CNT_W'(1);

    extra  = slow ? CNT_W'(div) : extra_ext;
    // half a core cycle plus the extra core cycles, in clk2x cycles
    halves = CNT_W'(1) + (extra << 1);
  end

endmodule

// File: rtl/hdma_steal_fsm.sv
module hdma_steal_fsm
  import hdma_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             ph,
  input  logic             start,
  input  logic [CNT_W-1:0] halves,
  input  logic             bus_hold,
  output steal_st_e        state,
  output logic             go
);

  steal_st_e        state_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             sync_done;
  logic             wait_done;

  always_comb begin
    // leaving sync on the edge that opens a second half-cycle
    sync_done = (state == ST_SYNC) & ~ph;
    // steal only on a core boundary, wait elapsed, bus free
    wait_done = (state == ST_WAIT) & (cnt == CNT_W'(1)) & ~bus_hold & ph;
    go        = wait_done;

    state_d = state;
    unique case (state)
      ST_IDLE:  if (start)     state_d = ST_SYNC;
      ST_SYNC:  if (sync_done) state_d = ST_WAIT;
      ST_WAIT:  if (wait_done) state_d = ST_ACC_A;
      ST_ACC_A:                state_d = ST_ACC_B;
      ST_ACC_B:                state_d = ST_REL;
      ST_REL:                  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase

    cnt_en = sync_done | ((state == ST_WAIT) & (cnt > CNT_W'(1)));
    cnt_d  = sync_done ? halves : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)      cnt <= CNT_W'(1);
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/hdma_steal_arb.sv
module hdma_steal_arb (
  input  logic clk2x,
  input  logic rst_n,
  input  logic ph,
  input  logic host_go,
  input  logic bdma_req,
  input  logic abuf_req,
  output logic bdma_gnt,
  output logic abuf_gnt
);

  logic bdma_d;
  logic abuf_d;
  logic bound_en;

  always_comb begin
    bound_en = ph;
    bdma_d   = ~host_go & bdma_req;
    abuf_d   = ~host_go & ~bdma_req & abuf_req;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      bdma_gnt <= 1'b0;
      abuf_gnt <= 1'b0;
    end else if (bound_en) begin
      bdma_gnt <= bdma_d;
      abuf_gnt <= abuf_d;
    end
  end

endmodule

// File: rtl/hdma_steal_port.sv
module hdma_steal_port
  import hdma_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 16,
  parameter int EXT_MAX = 3,
  parameter int WS_W    = 4,
  parameter int DIV_W   = 4,
  localparam int EXT_W  = $clog2(EXT_MAX + 1)
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack,
  input  logic [EXT_W-1:0]  ext_acc_cnt,
  input  logic [WS_W-1:0]   ext_wait,
  input  logic              slow_idle,
  input  logic [DIV_W-1:0]  slow_div,
  input  logic              bus_hold,
  input  logic              bdma_req,
  input  logic              abuf_req,
  output logic              bdma_gnt,
  output logic              abuf_gnt,
  output logic              steal_req,
  output logic              core_phase,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int E_EXT_MAX  = EXT_MAX * ((1 << WS_W) - 1) + EXT_MAX - 1;
  localparam int E_SLOW_MAX = (1 << DIV_W) - 1;
  localparam int E_MAX      = (E_EXT_MAX > E_SLOW_MAX) ? E_EXT_MAX : E_SLOW_MAX;
  localparam int CNT_W      = $clog2(2 * E_MAX + 2);

  logic             ph;
  logic             start;
  logic             accept;
  logic             lat_wr;
  logic             go;
  logic             rdata_en;
  logic [CNT_W-1:0] halves;
  steal_st_e        state;

  hdma_phase_gen u_phase (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .ph    (ph)
  );

  hdma_req_front #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_front (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .sel       (host_sel),
    .wr        (host_wr),
    .rd        (host_rd),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .accept    (accept),
    .start     (start),
    .lat_addr  (mem_addr),
    .lat_wdata (mem_wdata),
    .lat_wr    (lat_wr)
  );

  hdma_wait_calc #(
    .EXT_MAX (EXT_MAX),
    .EXT_W   (EXT_W),
    .WS_W    (WS_W),
    .DIV_W   (DIV_W),
    .CNT_W   (CNT_W)
  ) u_wait (
    .ext_cnt (ext_acc_cnt),
    .ws      (ext_wait),
    .slow    (slow_idle),
    .div     (slow_div),
    .halves  (halves)
  );

  hdma_steal_fsm #(
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .ph       (ph),
    .start    (start),
    .halves   (halves),
    .bus_hold (bus_hold),
    .state    (state),
    .go       (go)
  );

  hdma_steal_arb u_arb (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .ph       (ph),
    .host_go  (go),
    .bdma_req (bdma_req),
    .abuf_req (abuf_req),
    .bdma_gnt (bdma_gnt),
    .abuf_gnt (abuf_gnt)
  );

  always_comb begin
    accept     = (state == ST_IDLE);
    host_ack   = (state != ST_IDLE);
    steal_req  = (state == ST_WAIT);
    mem_en     = (state == ST_ACC_A);
    mem_we     = (state == ST_ACC_A) & lat_wr;
    core_phase = ph;
    rdata_en   = (state == ST_ACC_B) & ~lat_wr;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)        host_rdata <= '0;
    else if (rdata_en) host_rdata <= mem_rdata;
  end

endmodule

// File: rtl/hdma_steal_port_chk.sv
module hdma_steal_port_chk (
  input logic clk2x,
  input logic rst_n,
  input logic host_ack,
  input logic steal_req,
  input logic core_phase,
  input logic mem_en,
  input logic bus_hold,
  input logic bdma_gnt,
  input logic abuf_gnt
);

  AST_ACK_BUSY: assert property (@(posedge clk2x) disable iff (!rst_n)
    (steal_req || mem_en) |-> host_ack); // R2

  AST_STEAL_PHASE: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(steal_req) |-> core_phase); // R3

  AST_MEM_AFTER_STEAL: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(mem_en) |-> $past(steal_req)); // R4

  AST_MEM_HOLD_FREE: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(mem_en) |-> !$past(bus_hold)); // R6

  AST_MEM_ONE_CYCLE: assert property (@(posedge clk2x) disable iff (!rst_n)
    mem_en |=> !mem_en); // R7

  AST_MEM_PHASE: assert property (@(posedge clk2x) disable iff (!rst_n)
    mem_en |-> !core_phase); // R7

  AST_STEAL_DROP: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(steal_req) |-> mem_en); // R7

  AST_ACK_RELEASE: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(host_ack) |-> $past(mem_en, 3)); // R9

  AST_GNT_ONEHOT: assert property (@(posedge clk2x) disable iff (!rst_n)
    $onehot0({bdma_gnt, abuf_gnt})); // R10

  AST_GNT_NOT_HOST: assert property (@(posedge clk2x) disable iff (!rst_n)
    mem_en |-> !(bdma_gnt || abuf_gnt)); // R10

endmodule

bind hdma_steal_port hdma_steal_port_chk u_chk (
  .clk2x      (clk2x),
  .rst_n      (rst_n),
  .host_ack   (host_ack),
  .steal_req  (steal_req),
  .core_phase (core_phase),
  .mem_en     (mem_en),
  .bus_hold   (bus_hold),
  .bdma_gnt   (bdma_gnt),
  .abuf_gnt   (abuf_gnt)
);

// File: tb/sim_hdma_steal_port.sv
`timescale 1ns/1ps
module sim_hdma_steal_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [13:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ack;
  logic [1:0]  ext_acc_cnt = '0;
  logic [3:0]  ext_wait = '0;
  logic        slow_idle = 1'b0;
  logic [3:0]  slow_div = '0;
  logic        bus_hold = 1'b0, bdma_req = 1'b0, abuf_req = 1'b0;
  logic        bdma_gnt, abuf_gnt, steal_req, core_phase;
  logic        mem_en, mem_we;
  logic [13:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #10 clk = ~clk;

  hdma_steal_port u0 (
    .clk2x(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack(host_ack), .ext_acc_cnt(ext_acc_cnt),
    .ext_wait(ext_wait), .slow_idle(slow_idle), .slow_div(slow_div),
    .bus_hold(bus_hold), .bdma_req(bdma_req), .abuf_req(abuf_req),
    .bdma_gnt(bdma_gnt), .abuf_gnt(abuf_gnt), .steal_req(steal_req),
    .core_phase(core_phase), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0, en_cnt = 0;
  logic [15:0] ram [256];
  logic [15:0] shadow [256];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // behavioural memory behind the port
  always @(posedge clk) if (mem_en) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  // reference model: absolute edge times of each stage
  int c, t_steal, t_acc, halves_m;
  bit m_ph, m_busy, m_reqq, m_wr, e_bg, e_ag;
  logic [13:0] m_addr;
  logic [15:0] m_wdata;

  function automatic int halves_of(int x, int w, bit sl, int n);
    int e;
    if (sl) e = n;
    else if (x == 0) e = 0;
    else e = x * w + x - 1;
    return 1 + 2 * e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c = 0; m_ph = 0; m_busy = 0; m_reqq = 0; t_steal = -1; t_acc = -1;
      e_bg = 0; e_ag = 0; m_wr = 0; m_addr = '0; m_wdata = '0; halves_m = 1;
    end else begin
      bit phb, rq, rise;
      c++;
      phb = m_ph; m_ph = ~m_ph;
      rq = host_sel & (host_wr | host_rd);
      rise = rq & ~m_reqq; m_reqq = rq;
      if (!m_busy) begin
        if (rise) begin
          m_busy = 1; t_steal = -1; t_acc = -1;
          m_wr = host_wr; m_addr = host_addr; m_wdata = host_wdata;
        end
      end else if (t_steal < 0) begin
        if (!phb) begin
          t_steal = c;
          halves_m = halves_of(ext_acc_cnt, ext_wait, slow_idle, slow_div);
        end
      end else if (t_acc < 0) begin
        if (c >= t_steal + halves_m && !bus_hold && phb) t_acc = c;
      end else if (c == t_acc + 3) m_busy = 0;
      if (phb) begin
        e_bg = !(t_acc == c) && bdma_req;
        e_ag = !(t_acc == c) && !bdma_req && abuf_req;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit e_st, e_en;
    e_st = m_busy && t_steal >= 0 && t_acc < 0;
    e_en = m_busy && t_acc >= 0 && c == t_acc;
    if (mem_en) en_cnt++;
    chk(host_ack == m_busy, "R2", "host_ack", host_ack, m_busy);
    chk(steal_req == e_st, "R3", "steal_req", steal_req, e_st);
    chk(core_phase == m_ph, "R3", "core_phase", core_phase, m_ph);
    chk(mem_en == e_en, "R7", "mem_en", mem_en, e_en);
    chk(bdma_gnt == e_bg, "R10", "bdma_gnt", bdma_gnt, e_bg);
    chk(abuf_gnt == e_ag, "R10", "abuf_gnt", abuf_gnt, e_ag);
    if (e_en) begin
      chk(mem_we == m_wr, "R7", "mem_we", mem_we, m_wr);
      chk(mem_addr == m_addr, "R7", "mem_addr", mem_addr, m_addr);
      if (m_wr) chk(mem_wdata == m_wdata, "R7", "mem_wdata", mem_wdata, m_wdata);
    end
  end

  int seen5 = 0, seen6 = 0;

  task automatic run_txn(input bit wr, input int ad, input int d, input int x,
                         input int w, input bit sl, input int n,
                         input int hold_len, input int pad, input string rq);
    int lat = 0, k = 0, e0, h;
    @(negedge clk);
    ext_acc_cnt = 2'(x); ext_wait = 4'(w); slow_idle = sl; slow_div = 4'(n);
    repeat (pad) @(negedge clk);
    host_sel = 1; host_wr = wr; host_rd = !wr;
    host_addr = 14'(ad); host_wdata = 16'(d); bus_hold = (hold_len > 0);
    e0 = en_cnt;
    forever begin
      @(negedge clk);
      k++;
      if (k >= hold_len) bus_hold = 0;
      if (host_ack) lat++;
      else if (lat > 0) break;
      if (k > 400) break;
    end
    host_sel = 0; host_wr = 0; host_rd = 0;
    h = halves_of(x, w, sl, n);
    chk(en_cnt - e0 == 1, "R7", "mem_en pulses", en_cnt - e0, 1);
    if (hold_len == 0) begin
      chk(lat == h + 4 || lat == h + 5, rq, "ack latency", lat, h + 4);
      if (h == 1 && lat == 5) seen5++;
      if (h == 1 && lat == 6) seen6++;
    end else
      chk(lat >= hold_len + 3 && lat <= hold_len + h + 6, "R6",
          "held latency", lat, hold_len + 3);
    chk(host_ack == 0, "R9", "ack back to ready", host_ack, 0);
    if (wr) shadow[ad] = 16'(d);
    else chk(host_rdata == shadow[ad], "R8", "read data", host_rdata, shadow[ad]);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R12", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int e0;
    logic [15:0] keep;
    for (int i = 0; i < 256; i++) begin ram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(host_ack == 0 && steal_req == 0 && mem_en == 0, "R1", "ack/steal/en",
        {host_ack, steal_req, mem_en}, 0);
    chk(bdma_gnt == 0 && abuf_gnt == 0 && core_phase == 0, "R1", "gnt/phase",
        {bdma_gnt, abuf_gnt, core_phase}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R12: both start phases with no external access
    run_txn(1, 8'h10, 16'hA5C3, 0, 0, 0, 0, 0, 0, "R12");
    run_txn(1, 8'h11, 16'h1234, 0, 0, 0, 0, 0, 1, "R12");
    run_txn(0, 8'h10, 0, 0, 0, 0, 0, 0, 0, "R12");
    run_txn(0, 8'h11, 0, 0, 0, 0, 0, 0, 1, "R12");
    chk(seen5 > 0, "R3", "short sync seen", seen5, 1);
    chk(seen6 > 0, "R3", "long sync seen", seen6, 1);

    // R4: external access counts and wait states, stealers active
    bdma_req = 1;
    run_txn(1, 8'h20, 16'h0F0F, 1, 2, 0, 0, 0, 0, "R4");
    abuf_req = 1;
    run_txn(0, 8'h20, 0, 2, 1, 0, 0, 0, 1, "R4");
    bdma_req = 0;
    run_txn(1, 8'h21, 16'hBEEF, 3, 0, 0, 0, 0, 0, "R4");
    run_txn(0, 8'h21, 0, 3, 5, 0, 0, 0, 0, "R4");
    abuf_req = 0;

    // R5: slow idle overrides the external count
    run_txn(1, 8'h22, 16'h5A5A, 3, 7, 1, 3, 0, 0, "R5");
    run_txn(0, 8'h22, 0, 0, 0, 1, 0, 0, 1, "R5");

    // R6: bus held well past the computed wait, with both stealers asking
    bdma_req = 1; abuf_req = 1;
    run_txn(0, 8'h21, 0, 1, 0, 0, 0, 11, 0, "R6");
    bdma_req = 0;
    run_txn(1, 8'h23, 16'h7E7E, 0, 0, 0, 0, 8, 1, "R6");
    abuf_req = 0;
    run_txn(0, 8'h23, 0, 0, 0, 0, 0, 0, 0, "R8");

    // R11 and R2: second rising request while busy, both strobes high first
    keep = host_rdata;
    @(negedge clk);
    ext_acc_cnt = 2'd3; ext_wait = 4'd3; slow_idle = 0;
    host_sel = 1; host_wr = 1; host_rd = 1;
    host_addr = 14'h30; host_wdata = 16'hC0DE;
    e0 = en_cnt;
    repeat (4) @(negedge clk);
    host_sel = 0;
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_rd = 1; host_addr = 14'h31;
    while (host_ack) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(host_ack == 0, "R11", "held request retriggered", host_ack, 0);
    end
    host_sel = 0; host_rd = 0;
    chk(en_cnt - e0 == 1, "R11", "accesses for two rises", en_cnt - e0, 1);
    chk(host_rdata == keep, "R8", "write kept rdata", host_rdata, keep);
    shadow[8'h30] = 16'hC0DE;
    run_txn(0, 8'h30, 0, 0, 0, 0, 0, 0, 0, "R11");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule